// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Controller

This block is the interrupt unit beside a small 8-bit processor core with a 16-bit address space. It keeps a 5-bit source-enable register and a 5-bit pending-flag register. The core reaches both through a plain memory-mapped read/write port. Peripherals pulse request lines that set flag bits. The core drives a deferred-enable strobe (EI), an immediate disable strobe (DI) and an immediate re-enable strobe for the return-from-interrupt path, and these steer a master enable.

At each instruction-boundary strobe from the core, the block looks for a source that is enabled, flagged and allowed by the master enable. If it finds one, it picks the lowest-numbered such source and clears that source's flag. It also drops the master enable. Over the next cycles it drives two stack writes of the captured return PC, high byte first, while the dispatch keeps the core waiting for a fixed number of cycles. In the final cycle of that window it hands the core the source's vector and the lowered stack pointer.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: After reset the enable and flag registers are 0, the master enable and any deferred enable are off, and `busy`, `stk_we`, `pc_wr` and `sp_wr` are low.
- R2: A write at address 0xFFFF stores data bits 4..0 into the enable register, and a write at 0xFF0F stores them into the flag register. A read of either address returns the stored 5 bits with bits 7..5 read as 1. Any other address reads 0.
- R3: A request pulse on `src_req[n]` sets flag bit n on the next clock. This holds even when a flag-register write or a dispatch clear lands in the same cycle.
- R4: A dispatch starts only on a boundary strobe, only while `busy` is low, only with the master enable on, and only when some bit is set in both the enable and flag registers. A boundary strobe during `busy` has no effect.
- R5: Bit 0 has the highest priority and bit 4 the lowest. Source n is given the vector 0x40 + 8*n.
- R6: On the accepting clock, only the chosen source's flag bit is cleared and the master enable is cleared. Other pending flags are kept.
- R7: The first cycle after acceptance writes PC[15:8] to SP-1. The second cycle writes PC[7:0] to SP-2. Both addresses wrap modulo 2^16. PC and SP are the values sampled on the accepting clock.
- R8: `busy` stays high for exactly 20 cycles after acceptance. In the last of them, `pc_wr` and `sp_wr` pulse with the vector and with SP-2.
- R9: After an EI strobe, the next boundary turns the master enable on. The arbitration at that same boundary still uses the old, off value.
- R10: A DI strobe clears the master enable and any deferred enable on the next clock. DI wins over EI or the re-enable strobe in the same cycle.
- R11: The re-enable strobe turns the master enable on at the next clock, without waiting for a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Register access address |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| src_req | input | 5 | Peripheral request pulses, one per source |
| ime_on | input | 1 | Deferred master-enable strobe (EI) |
| ime_off | input | 1 | Immediate master-disable strobe (DI) |
| ime_reti | input | 1 | Immediate master-enable strobe from return path |
| insn_boundary | input | 1 | Instruction-boundary strobe from the core |
| core_pc | input | 16 | Current program counter |
| core_sp | input | 16 | Current stack pointer |
| busy | output | 1 | Dispatch sequence in progress; core waits |
| stk_we | output | 1 | Stack memory write strobe |
| stk_addr | output | 16 | Stack write address |
| stk_wdata | output | 8 | Stack write data |
| pc_wr | output | 1 | Load `pc_new` into the program counter |
| pc_new | output | 16 | Vector address |
| sp_wr | output | 1 | Load `sp_new` into the stack pointer |
| sp_new | output | 16 | Stack pointer after the two pushes |
| master_en | output | 1 | Current master enable |

## Verification
The flag register can be written in the same cycle as it changes in other ways: a software write or a dispatch clear of one bit can coincide with a peripheral request for another bit. The bench provokes both pairings on purpose. It writes the flag register while pulsing a request, and it pulses a request on the exact accepting boundary. It then reads the flag register back through the port and expects the request bit set and, for the dispatch case, only the served bit cleared. A second pairing is the EI promotion and the arbitration, which both act at one boundary. It is judged by confirming that no dispatch starts at that boundary and that one starts at the following boundary.

// File: rtl/irq_dispatch_pkg.sv
`timescale 1ns/1ps
package irq_dispatch_pkg;
   // Phase of the dispatch window, derived from the beat counter
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PUSH_HI,
      PH_PUSH_LO,
      PH_HOLD,
      PH_JUMP
   } disp_phase_e;

   // Index width for a source count, never below one bit
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank #(
   parameter int NUM_SRC   = 5,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int EN_ADDR   = 'hFFFF,
   parameter int FLAG_ADDR = 'hFF0F
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic [NUM_SRC-1:0] take_mask,
   output logic [NUM_SRC-1:0] en_q,
   output logic [NUM_SRC-1:0] flag_q
);
   localparam int PAD = DATA_W - NUM_SRC;
   localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_ADDR);
   localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

   logic hit_en, hit_flag;
   logic [NUM_SRC-1:0] flag_base, flag_d;

   assign hit_en   = (bus_addr == EN_A);
   assign hit_flag = (bus_addr == FLAG_A);

   // Software write first, then dispatch clear, then requests win
   assign flag_base = (bus_wr && hit_flag) ? bus_wdata[NUM_SRC-1:0] : flag_q;
   assign flag_d    = (flag_base & ~take_mask) | src_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= '0;
         flag_q <= '0;
      end else begin
         flag_q <= flag_d;
         if (bus_wr && hit_en) en_q <= bus_wdata[NUM_SRC-1:0];
      end
   end

   generate
      if (PAD > 0) begin : g_pad
         always_comb begin
            if (hit_en)        bus_rdata = {{PAD{1'b1}}, en_q};
            else if (hit_flag) bus_rdata = {{PAD{1'b1}}, flag_q};
            else               bus_rdata = '0;
         end
      end else begin : g_nopad
         always_comb begin
            if (hit_en)        bus_rdata = en_q;
            else if (hit_flag) bus_rdata = flag_q;
            else               bus_rdata = '0;
         end
      end
   endgenerate
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick
   import irq_dispatch_pkg::*;
#(
   parameter int NUM_SRC    = 5,
   parameter int ADDR_W     = 16,
   parameter int VEC_BASE   = 'h40,
   parameter int VEC_STRIDE = 8
) (
   input  logic [NUM_SRC-1:0]  cand,
   output logic                any_hit,
   output logic [NUM_SRC-1:0]  sel,
   output logic [ADDR_W-1:0]   vector
);
   localparam int IDX_W = idx_width(NUM_SRC);

   logic [NUM_SRC:0]   blocked;
   logic [IDX_W-1:0]   idx;

   assign blocked[0] = 1'b0;

   // Ripple chain: a lower index blocks every higher one
   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
         assign sel[i]       = cand[i] & ~blocked[i];
         assign blocked[i+1] = blocked[i] | cand[i];
      end
   endgenerate

   assign any_hit = blocked[NUM_SRC];

   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (sel[i]) idx = idx | IDX_W'(i);
      end
   end

   assign vector = ADDR_W'(VEC_BASE) + ADDR_W'(idx) * ADDR_W'(VEC_STRIDE);
endmodule

// File: rtl/irq_master_enable.sv
`timescale 1ns/1ps
module irq_master_enable (
   input  logic clk,
   input  logic rst_n,
   input  logic ei_stb,
   input  logic di_stb,
   input  logic reti_stb,
   input  logic bnd_ok,
   input  logic take,
   output logic ime_q,
   output logic pend_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ime_q  <= 1'b0;
         pend_q <= 1'b0;
      end else if (di_stb) begin
         ime_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (take)                ime_q <= 1'b0;
         else if (reti_stb)       ime_q <= 1'b1;
         else if (bnd_ok && pend_q) ime_q <= 1'b1;

         if (ei_stb)                         pend_q <= 1'b1;
         else if (take || (bnd_ok && pend_q)) pend_q <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_push_seq.sv
`timescale 1ns/1ps
module irq_push_seq
   import irq_dispatch_pkg::*;
#(
   parameter int ADDR_W          = 16,
   parameter int DATA_W          = 8,
   parameter int DISPATCH_CYCLES = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [ADDR_W-1:0] sp_in,
   input  logic [ADDR_W-1:0] vec_in,
   output logic              busy,
   output logic              stk_we,
   output logic [ADDR_W-1:0] stk_addr,
   output logic [DATA_W-1:0] stk_wdata,
   output logic              pc_wr,
   output logic [ADDR_W-1:0] pc_new,
   output logic              sp_wr,
   output logic [ADDR_W-1:0] sp_new
);
   localparam int CNT_W = $clog2(DISPATCH_CYCLES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DISPATCH_CYCLES - 1);

   logic              act_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] pc_q, sp_q, vec_q;
   logic [ADDR_W-1:0] sp_m1, sp_m2;
   disp_phase_e       phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
         pc_q  <= '0;
         sp_q  <= '0;
         vec_q <= '0;
      end else if (start && !act_q) begin
         act_q <= 1'b1;
         cnt_q <= '0;
         pc_q  <= pc_in;
         sp_q  <= sp_in;
         vec_q <= vec_in;
      end else if (act_q) begin
         if (cnt_q == LAST) begin
            act_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_comb begin
      if (!act_q)              phase = PH_IDLE;
      else if (cnt_q == '0)    phase = PH_PUSH_HI;
      else if (cnt_q == CNT_W'(1)) phase = PH_PUSH_LO;
      else if (cnt_q == LAST)  phase = PH_JUMP;
      else                     phase = PH_HOLD;
   end

   assign sp_m1 = sp_q - ADDR_W'(1);
   assign sp_m2 = sp_q - ADDR_W'(2);

   assign busy      = act_q;
   assign stk_we    = (phase == PH_PUSH_HI) || (phase == PH_PUSH_LO);
   assign stk_addr  = (phase == PH_PUSH_HI) ? sp_m1 : sp_m2;
   assign stk_wdata = (phase == PH_PUSH_HI) ? pc_q[ADDR_W-1 -: DATA_W] : pc_q[DATA_W-1:0];
   assign pc_wr     = (phase == PH_JUMP);
   assign sp_wr     = (phase == PH_JUMP);
   assign pc_new    = vec_q;
   assign sp_new    = sp_m2;
endmodule

// File: rtl/irq_dispatch_ctrl.sv
`timescale 1ns/1ps
module irq_dispatch_ctrl #(
   parameter int NUM_SRC         = 5,
   parameter int ADDR_W          = 16,
   parameter int DATA_W          = 8,
   parameter int EN_ADDR         = 'hFFFF,
   parameter int FLAG_ADDR       = 'hFF0F,
   parameter int VEC_BASE        = 'h40,
   parameter int VEC_STRIDE      = 8,
   parameter int DISPATCH_CYCLES = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic               ime_on,
   input  logic               ime_off,
   input  logic               ime_reti,
   input  logic               insn_boundary,
   input  logic [ADDR_W-1:0]  core_pc,
   input  logic [ADDR_W-1:0]  core_sp,
   output logic               busy,
   output logic               stk_we,
   output logic [ADDR_W-1:0]  stk_addr,
   output logic [DATA_W-1:0]  stk_wdata,
   output logic               pc_wr,
   output logic [ADDR_W-1:0]  pc_new,
   output logic               sp_wr,
   output logic [ADDR_W-1:0]  sp_new,
   output logic               master_en
);
   // Elaboration-time parameter checks
   generate
      if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
         $error("NUM_SRC must lie in 1..DATA_W");
      end
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("ADDR_W must be twice DATA_W for the two-byte push");
      end
      if (DISPATCH_CYCLES < 3) begin : g_bad_len
         $error("DISPATCH_CYCLES must cover two pushes and a jump");
      end
   endgenerate

   logic [NUM_SRC-1:0] en_bits, flag_bits, cand, sel, take_mask;
   logic [ADDR_W-1:0]  vec_sel;
   logic               any_hit, bnd_ok, accept, pend_q;

   assign cand      = en_bits & flag_bits;
   assign bnd_ok    = insn_boundary && !busy;
   assign accept    = bnd_ok && master_en && any_hit;
   assign take_mask = accept ? sel : '0;

   irq_flag_bank #(
      .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .EN_ADDR(EN_ADDR), .FLAG_ADDR(FLAG_ADDR)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .src_req(src_req), .take_mask(take_mask),
      .en_q(en_bits), .flag_q(flag_bits)
   );

   irq_prio_pick #(
      .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W),
      .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
   ) u_pick (
      .cand(cand), .any_hit(any_hit), .sel(sel), .vector(vec_sel)
   );

   irq_master_enable u_ime (
      .clk(clk), .rst_n(rst_n),
      .ei_stb(ime_on), .di_stb(ime_off), .reti_stb(ime_reti),
      .bnd_ok(bnd_ok), .take(accept),
      .ime_q(master_en), .pend_q(pend_q)
   );

   irq_push_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DISPATCH_CYCLES(DISPATCH_CYCLES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(accept),
      .pc_in(core_pc), .sp_in(core_sp), .vec_in(vec_sel),
      .busy(busy), .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
      .pc_wr(pc_wr), .pc_new(pc_new), .sp_wr(sp_wr), .sp_new(sp_new)
   );
endmodule

// File: rtl/irq_dispatch_chk.sv
`timescale 1ns/1ps
module irq_dispatch_chk #(
   parameter int NUM_SRC         = 5,
   parameter int ADDR_W          = 16,
   parameter int VEC_BASE        = 'h40,
   parameter int VEC_STRIDE      = 8,
   parameter int DISPATCH_CYCLES = 20
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic               stk_we,
   input logic [ADDR_W-1:0]  stk_addr,
   input logic               pc_wr,
   input logic [ADDR_W-1:0]  pc_new,
   input logic               sp_wr,
   input logic               master_en,
   input logic               ime_off,
   input logic               insn_boundary,
   input logic [NUM_SRC-1:0] src_req,
   input logic [NUM_SRC-1:0] flag_bits
);
   logic [15:0] run_len;

   always_ff @(posedge clk) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + 16'd1;
      else           run_len <= '0;
   end

   a_r3_req_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (src_req != '0) |=> ((flag_bits & $past(src_req)) == $past(src_req)));

   a_r4_start_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(insn_boundary));

   a_r6_ime_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !master_en);

   a_r7_high_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> stk_we);

   a_r7_low_below: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> (stk_we && stk_addr == $past(stk_addr) - ADDR_W'(1)));

   a_r5_vector_grid: assert property (@(posedge clk) disable iff (!rst_n)
      pc_wr |-> (int'(pc_new) >= VEC_BASE
                 && int'(pc_new) < VEC_BASE + VEC_STRIDE * NUM_SRC
                 && ((int'(pc_new) - VEC_BASE) % VEC_STRIDE) == 0));

   a_r8_jump_ends: assert property (@(posedge clk) disable iff (!rst_n)
      pc_wr |=> !busy);

   a_r8_window_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == 16'(DISPATCH_CYCLES)));

   a_r8_single_action: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stk_we, pc_wr}) && (pc_wr == sp_wr));

   a_r10_di_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ime_off |=> !master_en);
endmodule

bind irq_dispatch_ctrl irq_dispatch_chk #(
   .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE),
   .VEC_STRIDE(VEC_STRIDE), .DISPATCH_CYCLES(DISPATCH_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .stk_we(stk_we), .stk_addr(stk_addr),
   .pc_wr(pc_wr), .pc_new(pc_new), .sp_wr(sp_wr), .master_en(master_en),
   .ime_off(ime_off), .insn_boundary(insn_boundary), .src_req(src_req),
   .flag_bits(flag_bits)
);

// File: tb/irq_dispatch_ctrl_bench.sv
`timescale 1ns/1ps
module irq_dispatch_ctrl_bench;
   localparam int NCYC = 20;
   localparam logic [15:0] A_EN   = 16'hFFFF;
   localparam logic [15:0] A_FLAG = 16'hFF0F;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n;
   logic [15:0] bus_addr;
   logic        bus_wr;
   logic [7:0]  bus_wdata, bus_rdata;
   logic [4:0]  src_req;
   logic        ime_on, ime_off, ime_reti, insn_boundary;
   logic [15:0] core_pc, core_sp;
   logic        busy, stk_we, pc_wr, sp_wr, master_en;
   logic [15:0] stk_addr, pc_new, sp_new;
   logic [7:0]  stk_wdata;

   irq_dispatch_ctrl u_irq_dispatch_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req),
      .ime_on(ime_on), .ime_off(ime_off), .ime_reti(ime_reti),
      .insn_boundary(insn_boundary), .core_pc(core_pc), .core_sp(core_sp),
      .busy(busy), .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
      .pc_wr(pc_wr), .pc_new(pc_new), .sp_wr(sp_wr), .sp_new(sp_new),
      .master_en(master_en)
   );

   int n_run = 0, n_fail = 0;
   string cur_tag = "R2";

   // Reference state built from the requirements
   logic [4:0]  m_ie, m_if;
   logic        m_ime, m_pend, m_act;
   int          m_cnt;
   logic [15:0] m_pc, m_sp, m_vec;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input logic [15:0] a);
      if (a == A_EN)   return {3'b111, m_ie};
      if (a == A_FLAG) return {3'b111, m_if};
      return 8'h00;
   endfunction

   task automatic compare_all();
      chk({cur_tag, " read"}, 32'(bus_rdata), 32'(exp_read(bus_addr)));
      chk("R8 busy", 32'(busy), 32'(m_act));
      chk("R9 master_en", 32'(master_en), 32'(m_ime));
      chk("R7 stk_we", 32'(stk_we), 32'(m_act && m_cnt < 2));
      if (m_act && m_cnt == 0) begin
         chk("R7 hi addr", 32'(stk_addr), 32'(16'(m_sp - 16'd1)));
         chk("R7 hi data", 32'(stk_wdata), 32'(m_pc[15:8]));
      end
      if (m_act && m_cnt == 1) begin
         chk("R7 lo addr", 32'(stk_addr), 32'(16'(m_sp - 16'd2)));
         chk("R7 lo data", 32'(stk_wdata), 32'(m_pc[7:0]));
      end
      chk("R8 pc_wr", 32'(pc_wr), 32'(m_act && m_cnt == NCYC - 1));
      chk("R8 sp_wr", 32'(sp_wr), 32'(m_act && m_cnt == NCYC - 1));
      if (m_act && m_cnt == NCYC - 1) begin
         chk("R5 vector", 32'(pc_new), 32'(m_vec));
         chk("R7 sp_new", 32'(sp_new), 32'(16'(m_sp - 16'd2)));
      end
   endtask

   task automatic model_step();
      logic       bnd, acc;
      logic [4:0] cand, f;
      int         idx;
      bnd  = insn_boundary && !m_act;
      cand = m_ie & m_if;
      acc  = bnd && m_ime && (cand != 0);
      idx  = 0;
      for (int i = 4; i >= 0; i--) if (cand[i]) idx = i;
      f = (bus_wr && bus_addr == A_FLAG) ? bus_wdata[4:0] : m_if;
      if (acc) f[idx] = 1'b0;
      f = f | src_req;
      if (bus_wr && bus_addr == A_EN) m_ie = bus_wdata[4:0];
      if (ime_off) begin
         m_ime = 0; m_pend = 0;
      end else begin
         logic prom;
         prom = bnd && m_pend;
         if (acc) m_ime = 0; else if (ime_reti) m_ime = 1; else if (prom) m_ime = 1;
         if (ime_on) m_pend = 1; else if (acc || prom) m_pend = 0;
      end
      m_if = f;
      if (acc) begin
         m_act = 1; m_cnt = 0; m_pc = core_pc; m_sp = core_sp;
         m_vec = 16'(16'h40 + 8 * idx);
      end else if (m_act) begin
         if (m_cnt == NCYC - 1) begin m_act = 0; m_cnt = 0; end
         else m_cnt++;
      end
   endtask

   // One clock: inputs already set at the falling edge
   task automatic step(input logic b, input logic ei, input logic di, input logic rt,
                       input logic wr, input logic [15:0] a, input logic [7:0] d,
                       input logic [4:0] rq);
      insn_boundary = b; ime_on = ei; ime_off = di; ime_reti = rt;
      bus_wr = wr; bus_addr = a; bus_wdata = d; src_req = rq;
      #1;
      compare_all();
      model_step();
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, A_FLAG, 8'h00, 5'h00);
   endtask

   task automatic peek(input string tag, input logic [15:0] a, input logic [7:0] exp);
      bus_addr = a; bus_wr = 1'b0;
      #1;
      chk(tag, 32'(bus_rdata), 32'(exp));
   endtask

   bit done = 0;
   initial begin
      #(200000 * 20);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd9173);
      rst_n = 0; bus_addr = A_FLAG; bus_wr = 0; bus_wdata = 0; src_req = 0;
      ime_on = 0; ime_off = 0; ime_reti = 0; insn_boundary = 0;
      core_pc = 16'h1234; core_sp = 16'hD000;
      m_ie = 0; m_if = 0; m_ime = 0; m_pend = 0; m_act = 0; m_cnt = 0;
      m_pc = 0; m_sp = 0; m_vec = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      peek("R1 enable reg", A_EN, 8'hE0);
      peek("R1 flag reg", A_FLAG, 8'hE0);
      chk("R1 busy", 32'(busy), 0);
      chk("R1 master_en", 32'(master_en), 0);
      chk("R1 stk_we", 32'(stk_we), 0);
      chk("R1 pc_wr", 32'(pc_wr), 0);

      // R2 register access
      cur_tag = "R2";
      step(0, 0, 0, 0, 1, A_EN, 8'h1F, 0);
      step(0, 0, 0, 0, 1, A_FLAG, 8'hE0, 0);
      peek("R2 enable readback", A_EN, 8'hFF);
      peek("R2 flag readback", A_FLAG, 8'hE0);
      peek("R2 unmapped", 16'h1234, 8'h00);

      // R3 request beats a same-cycle flag write
      cur_tag = "R3";
      step(0, 0, 0, 0, 1, A_FLAG, 8'h01, 5'h04);
      peek("R3 write plus request", A_FLAG, 8'hE5);
      step(0, 0, 0, 0, 1, A_FLAG, 8'h00, 5'h00);

      // R9 deferred enable: first boundary promotes, second dispatches
      cur_tag = "R9";
      step(0, 0, 0, 0, 0, A_FLAG, 0, 5'h08);
      step(0, 1, 0, 0, 0, A_FLAG, 0, 0);
      step(1, 0, 0, 0, 0, A_FLAG, 0, 0);
      chk("R9 no dispatch at promoting boundary", 32'(busy), 0);
      chk("R9 enable now on", 32'(master_en), 1);
      core_pc = 16'hBEEF; core_sp = 16'h0001;
      step(1, 0, 0, 0, 0, A_FLAG, 0, 0);
      chk("R9 dispatch at next boundary", 32'(busy), 1);
      chk("R6 enable dropped", 32'(master_en), 0);
      // R4 boundary during busy ignored, R11 reti immediate
      cur_tag = "R4";
      step(0, 0, 0, 1, 0, A_FLAG, 0, 5'h01);
      chk("R11 reti immediate", 32'(master_en), 1);
      step(1, 0, 0, 0, 0, A_FLAG, 0, 0);
      peek("R4 flag kept during busy", A_FLAG, 8'hE1);
      idle(NCYC);
      chk("R4 idle after window", 32'(busy), 0);

      // R5/R6 priority among several, R3 request during dispatch clear
      cur_tag = "R6";
      core_pc = 16'h4321; core_sp = 16'h0000;
      step(0, 0, 0, 0, 1, A_FLAG, 8'h1C, 0);
      step(1, 0, 0, 0, 0, A_FLAG, 0, 5'h02);
      peek("R6 only bit2 cleared, R3 bit1 set", A_FLAG, 8'hFA);
      idle(NCYC + 1);

      // R10 DI cancels deferred enable; DI beats EI
      cur_tag = "R10";
      step(0, 0, 1, 0, 0, A_FLAG, 0, 0);
      step(0, 1, 0, 0, 0, A_FLAG, 0, 0);
      step(0, 0, 1, 0, 0, A_FLAG, 0, 0);
      step(1, 0, 0, 0, 0, A_FLAG, 0, 0);
      step(1, 0, 0, 0, 0, A_FLAG, 0, 0);
      chk("R10 no dispatch after cancel", 32'(busy), 0);
      step(0, 1, 1, 1, 0, A_FLAG, 0, 0);
      chk("R10 DI wins", 32'(master_en), 0);
      idle(2);

      // Random phase
      cur_tag = "R2";
      for (int c = 0; c < 6000; c++) begin
         logic [15:0] a;
         int sel;
         sel = $urandom % 3;
         a = (sel == 0) ? A_EN : (sel == 1) ? A_FLAG : 16'($urandom);
         core_pc = 16'($urandom);
         core_sp = ($urandom % 8 == 0) ? 16'($urandom % 2) : 16'($urandom);
         step(($urandom % 3) == 0, ($urandom % 10) == 0, ($urandom % 37) == 0,
              ($urandom % 15) == 0, ($urandom % 7) == 0, a, 8'($urandom),
              (($urandom % 5) == 0) ? 5'($urandom) : 5'h00);
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule